// File: doc/BRIEF.md
# Windowed Command and Interrupt-Status Port

This block is the single command/status location of a network controller's host register file. The host writes a 16-bit word holding a 5-bit opcode and an 11-bit argument. The block decodes that word, keeps the number of the register window that the host has selected, and issues one-cycle strobes that start, stop or reset the receive and transmit engines. It also holds the receive-filter bits that the MAC logic reads.

A read of the same location returns a status word with four parts: the selected window, a busy flag, the sticky per-source event bits and an interrupt latch. The engines report events on pulse inputs. The host chooses which of them raise the interrupt output with a mask command, and clears them with an acknowledge command.

A global-reset command returns all of this state to its reset values. After it, a settling period of programmable length follows, and during that period the port accepts no command.

Top module: `cmd_status_port`

## Requirements
- R1: A command is accepted at a rising clock edge when `cmd_we` is high and the busy bit is clear. The opcode is `cmd_data[15:11]` and the argument is `cmd_data[10:0]`. Its effect is visible after that edge.
- R2: Opcode 1 selects window `cmd_data[2:0]`, and argument bits 10..3 are ignored. `status_o[15:13]` reports the selected window.
- R3: `status_o` bit 0 is the interrupt latch. Bit 1 is adapter failure, bit 2 transmit done, bit 3 transmit space available, bit 4 receive done, bit 5 receive early, bit 6 host-requested interrupt, bit 7 statistics update and bit 12 busy. Bits 11..8 read 0, and the whole word reads 0x0000 after `rst_n` is applied.
- R4: An event input pulse sets its status bit (1,2,3,4,5,7) on the next edge and the bit stays set. Opcode 0x0C sets bit 6.
- R5: Opcode 0x0D clears each status bit 7..0 whose argument bit is 1. If an event arrives in the same cycle as the acknowledge that clears its bit, the bit stays set.
- R6: Opcode 0x0E loads the interrupt mask from argument bits 7..1. `intr_o` is the OR of (status bits 7..1 AND mask). The latch (bit 0) is set at the same edge as that OR becomes true. An acknowledge clears the latch only when, after that acknowledge, no enabled bit is pending.
- R7: Opcode 0x10 loads `filt_o` from argument bits 3..0: bit 0 individual, bit 1 multicast, bit 2 broadcast, bit 3 promiscuous. Higher argument bits are ignored. `filt_o` is 0 after reset.
- R8: Opcodes 4, 3 and 5 pulse `rx_stb_o` bit 0 (enable), bit 1 (disable) and bit 2 (reset) for exactly one cycle. `rx_on_o` becomes 1 on enable and 0 on disable or reset, and it is 0 after reset.
- R9: Opcodes 9, 10 and 11 pulse `tx_stb_o` bit 0 (enable), bit 1 (disable) and bit 2 (reset) for one cycle. `tx_on_o` becomes 1 on enable and 0 on disable or reset.
- R10: Opcode 0 pulses `glb_stb_o` and clears the window, mask, status bits, filter, `rx_on_o` and `tx_on_o`. Busy (bit 12) then reads 1 for exactly SETTLE_CYCLES cycles.
- R11: While busy is set, every command is ignored, including window selects.
- R12: Opcodes not named above (2, 6, 7, 8, 0x0F, 0x11 to 0x1F) change no state and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 16 | Command word: opcode and argument |
| ev_fail_i | input | 1 | Adapter failure event pulse |
| ev_tx_done_i | input | 1 | Transmit done event pulse |
| ev_tx_avail_i | input | 1 | Transmit space available event pulse |
| ev_rx_done_i | input | 1 | Receive done event pulse |
| ev_rx_early_i | input | 1 | Receive early event pulse |
| ev_stats_i | input | 1 | Statistics update event pulse |
| status_o | output | 16 | Status word read back at the command location |
| intr_o | output | 1 | Interrupt request |
| filt_o | output | 4 | Receive filter bits |
| rx_stb_o | output | 3 | Receive strobes {reset, disable, enable} |
| tx_stb_o | output | 3 | Transmit strobes {reset, disable, enable} |
| rx_on_o | output | 1 | Receiver enabled |
| tx_on_o | output | 1 | Transmitter enabled |
| glb_stb_o | output | 1 | Global reset strobe |

## Verification
The bench builds the block with SETTLE_CYCLES set to 6. This makes the whole busy period short enough to count cycle by cycle. It also lets a window-select be placed inside that period, so the bench can show the command is dropped, and then accepted again just after busy clears. The default value is a plain counter limit, so the smaller value exercises the same load, decrement and zero-detect path.

// File: rtl/csp_pkg.sv
// Shared opcodes and decoded-command type for the command/status port.
// Assumes a 16-bit command word with a 5-bit opcode on top.
package csp_pkg;
    localparam int CMD_W = 16;
    localparam int OP_W  = 5;
    localparam int ARG_W = CMD_W - OP_W;

    localparam logic [OP_W-1:0] OP_GLB_RST  = 5'h00;
    localparam logic [OP_W-1:0] OP_WIN_SEL  = 5'h01;
    localparam logic [OP_W-1:0] OP_RX_DIS   = 5'h03;
    localparam logic [OP_W-1:0] OP_RX_EN    = 5'h04;
    localparam logic [OP_W-1:0] OP_RX_RST   = 5'h05;
    localparam logic [OP_W-1:0] OP_TX_EN    = 5'h09;
    localparam logic [OP_W-1:0] OP_TX_DIS   = 5'h0A;
    localparam logic [OP_W-1:0] OP_TX_RST   = 5'h0B;
    localparam logic [OP_W-1:0] OP_REQ_INT  = 5'h0C;
    localparam logic [OP_W-1:0] OP_ACK      = 5'h0D;
    localparam logic [OP_W-1:0] OP_SET_MASK = 5'h0E;
    localparam logic [OP_W-1:0] OP_SET_FILT = 5'h10;

    typedef struct packed {
        logic             glb;
        logic             win;
        logic             rx_en;
        logic             rx_dis;
        logic             rx_rst;
        logic             tx_en;
        logic             tx_dis;
        logic             tx_rst;
        logic             req_int;
        logic             ack;
        logic             set_mask;
        logic             set_filt;
        logic [ARG_W-1:0] arg;
    } dec_t;
endpackage

// File: rtl/csp_cmd_decode.sv
// Combinational opcode decoder. Produces one action flag per known opcode,
// qualified by the accept condition; unknown opcodes yield no flag.
module csp_cmd_decode
    import csp_pkg::*;
(
    input  logic             accept_i,
    input  logic [CMD_W-1:0] cmd_i,
    output dec_t             dec_o
);
    logic [OP_W-1:0] op;
    assign op = cmd_i[CMD_W-1:ARG_W];

    // Map the accepted opcode to a single action flag.
    always_comb begin
        dec_o     = '0;
        dec_o.arg = cmd_i[ARG_W-1:0];
        if (accept_i) begin
            case (op)
                OP_GLB_RST:  dec_o.glb      = 1'b1;
                OP_WIN_SEL:  dec_o.win      = 1'b1;
                OP_RX_DIS:   dec_o.rx_dis   = 1'b1;
                OP_RX_EN:    dec_o.rx_en    = 1'b1;
                OP_RX_RST:   dec_o.rx_rst   = 1'b1;
                OP_TX_EN:    dec_o.tx_en    = 1'b1;
                OP_TX_DIS:   dec_o.tx_dis   = 1'b1;
                OP_TX_RST:   dec_o.tx_rst   = 1'b1;
                OP_REQ_INT:  dec_o.req_int  = 1'b1;
                OP_ACK:      dec_o.ack      = 1'b1;
                OP_SET_MASK: dec_o.set_mask = 1'b1;
                OP_SET_FILT: dec_o.set_filt = 1'b1;
                default:     dec_o.arg      = cmd_i[ARG_W-1:0];
            endcase
        end
    end
endmodule

// File: rtl/csp_settle_timer.sv
// Busy timer: loaded on a global reset, counts down to zero.
// Busy is high for exactly SETTLE_CYCLES cycles after the loading edge.
module csp_settle_timer #(
    parameter int SETTLE_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_CYCLES);

    logic [CNT_W-1:0] cnt;

    // Load on start, otherwise count down while non-zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (start_i)        cnt <= LOAD;
        else if (cnt != '0)      cnt <= cnt - 1'b1;
    end

    assign busy_o = (cnt != '0);
endmodule

// File: rtl/csp_intr_status.sv
// Sticky event bits, interrupt mask and interrupt latch.
// Bit 0 of the status byte is the latch; bits N_BITS-1..1 are sources.
// Assumes set and clear requests are single-cycle.
module csp_intr_status #(
    parameter int N_BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_all_i,
    input  logic [N_BITS-1:1] set_i,
    input  logic [N_BITS-1:0] clr_i,
    input  logic              mask_load_i,
    input  logic [N_BITS-1:1] mask_val_i,
    output logic [N_BITS-1:0] stat_o,
    output logic              intr_o
);
    logic [N_BITS-1:1] bits_q, bits_d;
    logic [N_BITS-1:1] mask_q, mask_d;
    logic              latch_q, latch_d;

    // Next state: sets win over clears, global clear wins over all.
    always_comb begin
        bits_d  = (bits_q & ~clr_i[N_BITS-1:1]) | set_i;
        mask_d  = mask_load_i ? mask_val_i : mask_q;
        latch_d = (latch_q & ~clr_i[0]) | (|(bits_d & mask_d));
        if (clear_all_i) begin
            bits_d  = '0;
            mask_d  = '0;
            latch_d = 1'b0;
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q  <= '0;
            mask_q  <= '0;
            latch_q <= 1'b0;
        end else begin
            bits_q  <= bits_d;
            mask_q  <= mask_d;
            latch_q <= latch_d;
        end
    end

    assign stat_o = {bits_q, latch_q};
    assign intr_o = |(bits_q & mask_q);
endmodule

// File: rtl/csp_chan_ctl.sv
// Per-engine control: registered one-cycle strobes {reset, disable, enable}
// and an enabled level. The engine is off after reset.
module csp_chan_ctl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       en_i,
    input  logic       dis_i,
    input  logic       rst_i,
    output logic [2:0] stb_o,
    output logic       on_o
);
    // Strobe register and enable level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_o <= '0;
            on_o  <= 1'b0;
        end else begin
            stb_o <= {rst_i, dis_i, en_i};
            if (clear_i || dis_i || rst_i) on_o <= 1'b0;
            else if (en_i)                 on_o <= 1'b1;
        end
    end
endmodule

// File: rtl/cmd_status_port.sv
// Command/status port top. Accepts command words, holds the window number
// and receive filter, and assembles the status word.
// Assumes cmd_we is a single-cycle write strobe from the host bus.
module cmd_status_port
    import csp_pkg::*;
#(
    parameter int SETTLE_CYCLES = 1000,
    parameter int WIN_W         = 3,
    parameter int FILT_W        = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [CMD_W-1:0] cmd_data,
    input  logic             ev_fail_i,
    input  logic             ev_tx_done_i,
    input  logic             ev_tx_avail_i,
    input  logic             ev_rx_done_i,
    input  logic             ev_rx_early_i,
    input  logic             ev_stats_i,
    output logic [CMD_W-1:0] status_o,
    output logic             intr_o,
    output logic [FILT_W-1:0] filt_o,
    output logic [2:0]       rx_stb_o,
    output logic [2:0]       tx_stb_o,
    output logic             rx_on_o,
    output logic             tx_on_o,
    output logic             glb_stb_o
);
    localparam int N_BITS  = 8;
    localparam int RSV_W   = CMD_W - WIN_W - 1 - N_BITS;

    logic              busy;
    logic              accept;
    dec_t              dec;
    logic [WIN_W-1:0]  win_q;
    logic [N_BITS-1:0] stat;
    logic [N_BITS-1:1] ev_set;
    logic [N_BITS-1:0] ack_clr;
    logic              unused_arg;

    assign accept = cmd_we && !busy;

    csp_cmd_decode u_dec (
        .accept_i (accept),
        .cmd_i    (cmd_data),
        .dec_o    (dec)
    );

    csp_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (dec.glb),
        .busy_o  (busy)
    );

    // Event sources in status-bit order; bit 6 comes from the host.
    assign ev_set  = {ev_stats_i, dec.req_int, ev_rx_early_i, ev_rx_done_i,
                      ev_tx_avail_i, ev_tx_done_i, ev_fail_i};
    assign ack_clr = dec.ack ? dec.arg[N_BITS-1:0] : '0;

    csp_intr_status #(.N_BITS(N_BITS)) u_intr (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_all_i (dec.glb),
        .set_i       (ev_set),
        .clr_i       (ack_clr),
        .mask_load_i (dec.set_mask),
        .mask_val_i  (dec.arg[N_BITS-1:1]),
        .stat_o      (stat),
        .intr_o      (intr_o)
    );

    csp_chan_ctl u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (dec.glb),
        .en_i    (dec.rx_en),
        .dis_i   (dec.rx_dis),
        .rst_i   (dec.rx_rst),
        .stb_o   (rx_stb_o),
        .on_o    (rx_on_o)
    );

    csp_chan_ctl u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (dec.glb),
        .en_i    (dec.tx_en),
        .dis_i   (dec.tx_dis),
        .rst_i   (dec.tx_rst),
        .stb_o   (tx_stb_o),
        .on_o    (tx_on_o)
    );

    // Window number, receive filter and global-reset strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q     <= '0;
            filt_o    <= '0;
            glb_stb_o <= 1'b0;
        end else begin
            glb_stb_o <= dec.glb;
            if (dec.glb) begin
                win_q  <= '0;
                filt_o <= '0;
            end else begin
                if (dec.win)      win_q  <= dec.arg[WIN_W-1:0];
                if (dec.set_filt) filt_o <= dec.arg[FILT_W-1:0];
            end
        end
    end

    assign unused_arg = ^dec.arg[ARG_W-1:N_BITS];

    // Status word: window, busy, reserved zeros, event byte.
    assign status_o = {win_q, busy, {RSV_W{1'b0}}, stat};
endmodule

// File: rtl/cmd_status_port_chk.sv
// Protocol checker for cmd_status_port, bound to every instance.
module cmd_status_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] status_o,
    input logic        intr_o,
    input logic [3:0]  filt_o,
    input logic [2:0]  rx_stb_o,
    input logic [2:0]  tx_stb_o,
    input logic        rx_on_o,
    input logic        tx_on_o,
    input logic        glb_stb_o
);
    // R6
    intr_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intr_o |-> status_o[0]);

    // R11
    busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[12] |=> $stable(status_o[15:13]));

    // R8
    rx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_stb_o));

    // R8
    rx_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_stb_o[0] |-> rx_on_o) and ((rx_stb_o[1] || rx_stb_o[2]) |-> !rx_on_o));

    // R9
    tx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_stb_o));

    // R9
    tx_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_stb_o[0] |-> tx_on_o) and ((tx_stb_o[1] || tx_stb_o[2]) |-> !tx_on_o));

    // R10
    glb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        glb_stb_o |-> (status_o[12] && status_o[15:13] == 3'd0 && filt_o == 4'd0
                       && !rx_on_o && !tx_on_o && !intr_o));
endmodule

bind cmd_status_port cmd_status_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .status_o  (status_o),
    .intr_o    (intr_o),
    .filt_o    (filt_o),
    .rx_stb_o  (rx_stb_o),
    .tx_stb_o  (tx_stb_o),
    .rx_on_o   (rx_on_o),
    .tx_on_o   (tx_on_o),
    .glb_stb_o (glb_stb_o)
);

// File: tb/cmd_status_port_bench.sv
module cmd_status_port_bench;
    localparam int SETTLE = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [15:0] cmd_data = '0;
    logic        ev_fail = 0, ev_tx_done = 0, ev_tx_avail = 0;
    logic        ev_rx_done = 0, ev_rx_early = 0, ev_stats = 0;
    logic [15:0] status;
    logic        intr;
    logic [3:0]  filt;
    logic [2:0]  rx_stb, tx_stb;
    logic        rx_on, tx_on, glb_stb;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cmd_status_port #(.SETTLE_CYCLES(SETTLE)) u_cmd_status_port (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
        .ev_fail_i(ev_fail), .ev_tx_done_i(ev_tx_done), .ev_tx_avail_i(ev_tx_avail),
        .ev_rx_done_i(ev_rx_done), .ev_rx_early_i(ev_rx_early), .ev_stats_i(ev_stats),
        .status_o(status), .intr_o(intr), .filt_o(filt), .rx_stb_o(rx_stb),
        .tx_stb_o(tx_stb), .rx_on_o(rx_on), .tx_on_o(tx_on), .glb_stb_o(glb_stb)
    );

    // {expected intr, command, expected status after the accepting edge}
    localparam logic [32:0] VEC [9] = '{
        {1'b0, 16'h0805, 16'hA000},  // R2 window 5
        {1'b0, 16'h0FFA, 16'h4000},  // R2 window 2, high arg bits ignored
        {1'b0, 16'h6000, 16'h4040},  // R4 host interrupt request
        {1'b1, 16'h7040, 16'h4041},  // R6 mask bit 6 -> latch and intr
        {1'b0, 16'h6841, 16'h4000},  // R5 ack bits 6 and 0
        {1'b0, 16'hF807, 16'h4000},  // R12 opcode 0x1F ignored
        {1'b0, 16'h3000, 16'h4000},  // R12 opcode 6 ignored
        {1'b0, 16'h7FFF, 16'h4000},  // R12 opcode 0x0F ignored
        {1'b0, 16'h0807, 16'hE000}   // R1 window 7 accepted
    };

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send(input logic [15:0] w);
        cmd_data = w;
        cmd_we   = 1'b1;
        @(negedge clk);
        cmd_we   = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int busy_n;
        repeat (3) tick();
        // R3 reset state
        chk("R3 reset status", status, 16'h0000);
        chk("R7 reset filter", {12'd0, filt}, 16'h0000);
        chk("R8 reset rx off", {15'd0, rx_on}, 16'h0000);
        chk("R9 reset tx off", {15'd0, tx_on}, 16'h0000);
        rst_n = 1'b1;
        tick();

        // Table walk: R1 R2 R4 R5 R6 R12
        for (int i = 0; i < 9; i++) begin
            send(VEC[i][31:16]);
            chk("R1/R2/R12 table status", status, VEC[i][15:0]);
            chk("R6 table intr", {15'd0, intr}, {15'd0, VEC[i][32]});
        end

        // R7 filter
        send(16'h800F);
        chk("R7 filter all", {12'd0, filt}, 16'h000F);
        send(16'h80F5);
        chk("R7 filter high arg ignored", {12'd0, filt}, 16'h0005);

        // R8 receiver strobes and level
        send(16'h2000);
        chk("R8 rx enable strobe", {13'd0, rx_stb}, 16'h0001);
        chk("R8 rx on", {15'd0, rx_on}, 16'h0001);
        tick();
        chk("R8 rx strobe one cycle", {13'd0, rx_stb}, 16'h0000);
        send(16'h1800);
        chk("R8 rx disable strobe", {13'd0, rx_stb}, 16'h0002);
        chk("R8 rx off after disable", {15'd0, rx_on}, 16'h0000);
        send(16'h2000);
        send(16'h2800);
        chk("R8 rx reset strobe", {13'd0, rx_stb}, 16'h0004);
        chk("R8 rx off after reset", {15'd0, rx_on}, 16'h0000);

        // R9 transmitter strobes and level
        send(16'h4800);
        chk("R9 tx enable strobe", {13'd0, tx_stb}, 16'h0001);
        chk("R9 tx on", {15'd0, tx_on}, 16'h0001);
        send(16'h5000);
        chk("R9 tx disable strobe", {13'd0, tx_stb}, 16'h0002);
        chk("R9 tx off", {15'd0, tx_on}, 16'h0000);
        send(16'h5800);
        chk("R9 tx reset strobe", {13'd0, tx_stb}, 16'h0004);
        tick();
        chk("R9 tx strobe one cycle", {13'd0, tx_stb}, 16'h0000);

        // R4 R6 events, mask and latch
        send(16'h7004);
        ev_tx_done = 1'b1; tick(); ev_tx_done = 1'b0;
        chk("R4 tx done sets bit 2 with latch", status & 16'h00FF, 16'h0005);
        chk("R6 intr on enabled event", {15'd0, intr}, 16'h0001);
        send(16'h6801);
        chk("R6 latch held while pending", status & 16'h00FF, 16'h0005);
        send(16'h6805);
        chk("R5 ack clears bits", status & 16'h00FF, 16'h0000);
        chk("R6 intr drops", {15'd0, intr}, 16'h0000);
        send(16'h7000);
        ev_rx_done = 1'b1; tick(); ev_rx_done = 1'b0;
        chk("R6 masked event no latch", status & 16'h00FF, 16'h0010);
        chk("R6 masked event no intr", {15'd0, intr}, 16'h0000);
        ev_rx_done = 1'b1; send(16'h6810); ev_rx_done = 1'b0;
        chk("R5 event wins over ack", status & 16'h00FF, 16'h0010);
        send(16'h70FE);
        ev_fail = 1; ev_tx_avail = 1; ev_rx_early = 1; ev_stats = 1;
        tick();
        ev_fail = 0; ev_tx_avail = 0; ev_rx_early = 0; ev_stats = 0;
        chk("R4 all sources", status & 16'h00FF, 16'h00BB);
        chk("R3 reserved bits zero", status & 16'h0F00, 16'h0000);
        send(16'h68FF);
        chk("R5 ack all", status & 16'h00FF, 16'h0000);

        // R10 R11 global reset and settling
        send(16'h8005);
        send(16'h2000);
        send(16'h4800);
        send(16'h6000);
        send(16'h0000);
        chk("R10 status after global reset", status, 16'h1000);
        chk("R10 global strobe", {15'd0, glb_stb}, 16'h0001);
        chk("R10 filter cleared", {12'd0, filt}, 16'h0000);
        chk("R10 engines off", {14'd0, rx_on, tx_on}, 16'h0000);
        busy_n = 0;
        for (int i = 0; i < 20; i++) begin
            if (status[12]) busy_n++;
            if (i == 1) send(16'h0803);
            else tick();
        end
        chk("R10 busy length", 16'(busy_n), 16'(SETTLE));
        chk("R11 window select ignored while busy", status, 16'h0000);
        send(16'h0803);
        chk("R11 accepted after busy", status, 16'h6000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule